// File: doc/BRIEF.md
# Byte ALU with Nibble-Carry Flags

This block is the arithmetic and logic stage of a small 8-bit processor datapath. Each cycle in which `op_en` is high, it combines the accumulator and one operand under a 4-bit operation code, together with the incoming flag nibble. On that clock edge it registers an 8-bit result and four flags: zero, subtract, half-carry and carry.

Every arithmetic operation reports a carry out of the low nibble as well as out of the full byte. A decimal-adjust operation uses those flags to turn the result of a previous binary add or subtract of two packed-BCD bytes back into packed BCD.

The caller chooses where the result goes. When the operation is a compare, the registered result is the unchanged accumulator.

Top module: `alu8_core`

## Requirements
- R1: Flag nibble layout is bit 3 zero (Z), bit 2 subtract (N), bit 1 half-carry (H), bit 0 carry (C), on both `flg_in` and `flg_q`. While reset is active, `res_q` and `flg_q` read zero. A result is registered on the rising edge at which `op_en` is high and is visible after that edge.
- R2: While `op_en` is low, `res_q` and `flg_q` keep their values whatever the other inputs do.
- R3: Code 0x0 adds and code 0x1 adds with the incoming C. H is set when the low-nibble sum plus carry-in exceeds 0xF. C is set when the 9-bit sum exceeds 0xFF. N is cleared.
- R4: Code 0x2 subtracts and code 0x3 subtracts with the incoming C as a borrow. C is set on a borrow from the full byte. H is set on a borrow from the low nibble minus carry-in minus the operand's low nibble. N is set.
- R5: Code 0x7 compares. Its flags equal those of code 0x2, with Z taken from the difference, while `res_q` receives the accumulator unchanged.
- R6: Code 0x4 (AND) gives N=0, H=1, C=0. Codes 0x5 (XOR) and 0x6 (OR) clear N, H and C.
- R7: Code 0x8 increments and code 0x9 decrements the operand input rather than the accumulator. C keeps its incoming value. Increment clears N and sets H when the operand's low nibble was 0xF. Decrement sets N and sets H when that nibble was 0x0.
- R8: Code 0xB inverts the accumulator and sets N and H. Code 0xC sets C. Code 0xD inverts C. Both 0xC and 0xD clear N and H and output the accumulator unchanged. All three keep Z.
- R9: Code 0xA with N=0 adds 0x06 when H is set or the low nibble exceeds 9. In the same cycle it adds 0x60, and sets C, when C is set or the accumulator exceeds 0x99. C is otherwise cleared.
- R10: Code 0xA with N=1 subtracts 0x06 when H is set and subtracts 0x60 when C is set. C is kept. For both directions of decimal adjust, H is cleared and N is kept.
- R11: Z is set exactly when the 8-bit result is zero for codes 0x0 to 0xA. Code 0x7 takes Z from the difference.
- R12: Codes 0xE and 0xF output the accumulator unchanged and pass all four incoming flags through.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_en | input | 1 | Clock enable: register a new result this edge |
| op_sel | input | 4 | Operation code |
| acc_in | input | 8 | Accumulator operand |
| opd_in | input | 8 | Second operand; also the source for increment and decrement |
| flg_in | input | 4 | Incoming flags {Z,N,H,C} |
| res_q | output | 8 | Registered result |
| flg_q | output | 4 | Registered flags {Z,N,H,C} |

## Verification
The two functions that can act in the same cycle are the low-nibble correction and the high-nibble correction of decimal adjust. In the add direction, the carry update is also decided by the second of these. The bench provokes both at once with directed values: an accumulator of 0x9A with clear flags, and with N, H and C all set in the subtract direction. Random stimulus also reaches both cases. A bench model decides each correction on its own, and the bench judges the design by comparing its summed byte and flags with that model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD   = 4'h0,
    OP_ADC   = 4'h1,
    OP_SUB   = 4'h2,
    OP_SBC   = 4'h3,
    OP_AND   = 4'h4,
    OP_XOR   = 4'h5,
    OP_OR    = 4'h6,
    OP_CMP   = 4'h7,
    OP_INC   = 4'h8,
    OP_DEC   = 4'h9,
    OP_DADJ  = 4'hA,
    OP_INV   = 4'hB,
    OP_SETC  = 4'hC,
    OP_FLIPC = 4'hD,
    OP_RSV_E = 4'hE,
    OP_RSV_F = 4'hF
  } alu_op_e;

  typedef struct packed {
    logic z;
    logic n;
    logic h;
    logic c;
  } alu_flags_t;

endpackage

// File: rtl/alu8_rst_sync.sv
module alu8_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cout,
  output logic         hout
);

  localparam int NIB = W / 2;

  logic [NIB:0] lo;
  logic [W:0]   full;

  // The extra top bit is the carry (add) or the borrow (subtract).
  always_comb begin
    if (sub) begin
      lo   = {1'b0, a[NIB-1:0]} - {1'b0, b[NIB-1:0]} - {{NIB{1'b0}}, cin};
      full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
    end else begin
      lo   = {1'b0, a[NIB-1:0]} + {1'b0, b[NIB-1:0]} + {{NIB{1'b0}}, cin};
      full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
    end
  end

  assign sum  = full[W-1:0];
  assign cout = full[W];
  assign hout = lo[NIB];

endmodule

// File: rtl/alu8_daa.sv
module alu8_daa
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  alu_flags_t   fin,
  output logic [W-1:0] res,
  output logic         cout
);

  localparam int            NIB     = W / 2;
  localparam logic [W-1:0]  ADJ_LO  = W'(6);
  localparam logic [W-1:0]  ADJ_HI  = ADJ_LO << NIB;
  localparam logic [NIB-1:0] DIG_MAX = NIB'(9);
  localparam logic [W-1:0]  BYTE_MAX = (W'(9) << NIB) | W'(9);

  logic         fix_lo;
  logic         fix_hi;
  logic [W-1:0] adj;

  always_comb begin
    if (fin.n) begin
      fix_lo = fin.h;
      fix_hi = fin.c;
    end else begin
      fix_lo = fin.h || (a[NIB-1:0] > DIG_MAX);
      fix_hi = fin.c || (a > BYTE_MAX);
    end
    adj  = (fix_lo ? ADJ_LO : '0) | (fix_hi ? ADJ_HI : '0);
    res  = fin.n ? (a - adj) : (a + adj);
    cout = fin.n ? fin.c : fix_hi;
  end

endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_en,
  input  logic [OP_W-1:0]   op_sel,
  input  logic [DATA_W-1:0] acc_in,
  input  logic [DATA_W-1:0] opd_in,
  input  logic [3:0]        flg_in,
  output logic [DATA_W-1:0] res_q,
  output logic [3:0]        flg_q
);

  logic              rst_sync_n;
  alu_op_e           op;
  alu_flags_t        fi;
  alu_flags_t        flg_d;
  logic [DATA_W-1:0] res_d;

  logic              main_cin;
  logic              main_sub;
  logic [DATA_W-1:0] main_sum;
  logic              main_cout;
  logic              main_hout;

  logic [DATA_W-1:0] step_sum;
  logic              step_cout;
  logic              step_hout;

  logic [DATA_W-1:0] dadj_res;
  logic              dadj_cout;

  logic              upd_z;
  logic [DATA_W-1:0] z_src;

  assign op = alu_op_e'(op_sel);
  assign fi = alu_flags_t'(flg_in);

  alu8_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign main_cin = fi.c && (op == OP_ADC || op == OP_SBC);
  assign main_sub = (op == OP_SUB) || (op == OP_SBC) || (op == OP_CMP);

  alu8_addsub #(.W(DATA_W)) u_main (
    .a    (acc_in),
    .b    (opd_in),
    .cin  (main_cin),
    .sub  (main_sub),
    .sum  (main_sum),
    .cout (main_cout),
    .hout (main_hout)
  );

  alu8_addsub #(.W(DATA_W)) u_step (
    .a    (opd_in),
    .b    (DATA_W'(1)),
    .cin  (1'b0),
    .sub  (op == OP_DEC),
    .sum  (step_sum),
    .cout (step_cout),
    .hout (step_hout)
  );

  alu8_daa #(.W(DATA_W)) u_dadj (
    .a    (acc_in),
    .fin  (fi),
    .res  (dadj_res),
    .cout (dadj_cout)
  );

  // Next-state: result byte and flags
  always_comb begin
    res_d = acc_in;
    flg_d = fi;
    upd_z = 1'b1;
    z_src = '0;
    unique case (op)
      OP_ADD, OP_ADC: begin
        res_d = main_sum;
        flg_d = '{z: 1'b0, n: 1'b0, h: main_hout, c: main_cout};
      end
      OP_SUB, OP_SBC: begin
        res_d = main_sum;
        flg_d = '{z: 1'b0, n: 1'b1, h: main_hout, c: main_cout};
      end
      OP_CMP: begin
        res_d = acc_in;
        flg_d = '{z: 1'b0, n: 1'b1, h: main_hout, c: main_cout};
      end
      OP_AND: begin
        res_d = acc_in & opd_in;
        flg_d = '{z: 1'b0, n: 1'b0, h: 1'b1, c: 1'b0};
      end
      OP_XOR: begin
        res_d = acc_in ^ opd_in;
        flg_d = '{z: 1'b0, n: 1'b0, h: 1'b0, c: 1'b0};
      end
      OP_OR: begin
        res_d = acc_in | opd_in;
        flg_d = '{z: 1'b0, n: 1'b0, h: 1'b0, c: 1'b0};
      end
      OP_INC: begin
        res_d = step_sum;
        flg_d = '{z: 1'b0, n: 1'b0, h: step_hout, c: fi.c};
      end
      OP_DEC: begin
        res_d = step_sum;
        flg_d = '{z: 1'b0, n: 1'b1, h: step_hout, c: fi.c};
      end
      OP_DADJ: begin
        res_d = dadj_res;
        flg_d = '{z: 1'b0, n: fi.n, h: 1'b0, c: dadj_cout};
      end
      OP_INV: begin
        res_d = ~acc_in;
        flg_d = '{z: fi.z, n: 1'b1, h: 1'b1, c: fi.c};
        upd_z = 1'b0;
      end
      OP_SETC: begin
        flg_d = '{z: fi.z, n: 1'b0, h: 1'b0, c: 1'b1};
        upd_z = 1'b0;
      end
      OP_FLIPC: begin
        flg_d = '{z: fi.z, n: 1'b0, h: 1'b0, c: ~fi.c};
        upd_z = 1'b0;
      end
      default: begin
        upd_z = 1'b0;
      end
    endcase
    // Increment wraps to zero exactly when it carries out of the byte.
    if (op == OP_CMP) begin
      z_src = main_sum;
    end else begin
      z_src = res_d;
    end
    if (upd_z) begin
      if (op == OP_INC) begin
        flg_d.z = step_cout;
      end else begin
        flg_d.z = (z_src == '0);
      end
    end
  end

  // Register with explicit clock enable
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
      flg_q <= '0;
    end else if (op_en) begin
      res_q <= res_d;
      flg_q <= flg_d;
    end
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !op_en |=> ($stable(res_q) && $stable(flg_q))); // R2

  AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_en && op_sel == OP_CMP) |=> (res_q == $past(acc_in))); // R5

  AST_STEP_KEEPS_C: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_en && (op_sel == OP_INC || op_sel == OP_DEC)) |=> (flg_q[0] == $past(flg_in[0]))); // R7

  AST_AND_FLAGS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_en && op_sel == OP_AND) |=> (flg_q[2:0] == 3'b010)); // R6

  AST_DADJ_CLEARS_H: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_en && op_sel == OP_DADJ) |=> (!flg_q[1] && flg_q[2] == $past(flg_in[2]))); // R10

  AST_ZERO_TRACKS_RESULT: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_en && op_sel <= OP_DADJ && op_sel != OP_CMP) |=> (flg_q[3] == (res_q == '0))); // R11

  AST_RESERVED_PASS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (op_en && op_sel >= OP_RSV_E) |=> (flg_q == $past(flg_in) && res_q == $past(acc_in))); // R12

endmodule

// File: tb/tb_alu8_core.sv
module tb_alu8_core;

  logic       clk;
  logic       rst_n;
  logic       op_en;
  logic [3:0] op_sel;
  logic [7:0] acc_in;
  logic [7:0] opd_in;
  logic [3:0] flg_in;
  logic [7:0] res_q;
  logic [3:0] flg_q;

  int checks;
  int errors;
  bit done;

  alu8_core #(.DATA_W(8)) dut (
    .clk    (clk),
    .rst_n  (rst_n),
    .op_en  (op_en),
    .op_sel (op_sel),
    .acc_in (acc_in),
    .opd_in (opd_in),
    .flg_in (flg_in),
    .res_q  (res_q),
    .flg_q  (flg_q)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Reference: returns {result, Z, N, H, C}
  function automatic logic [11:0] model(input int op, input int a, input int b, input logic [3:0] f);
    int r; int t; int ci;
    logic z, n, h, c;
    z = f[3]; n = f[2]; h = f[1]; c = f[0];
    r = a;
    ci = f[0] ? 1 : 0;
    case (op)
      0, 1: begin
        if (op == 0) ci = 0;
        t = a + b + ci;
        h = ((a % 16) + (b % 16) + ci) > 15;
        c = t > 255; n = 0; r = t % 256; z = (r == 0);
      end
      2, 3, 7: begin
        if (op != 3) ci = 0;
        t = a - b - ci;
        h = ((a % 16) - (b % 16) - ci) < 0;
        c = t < 0; n = 1; t = (t + 512) % 256; z = (t == 0);
        r = (op == 7) ? a : t;
      end
      4: begin r = a & b; n = 0; h = 1; c = 0; z = (r == 0); end
      5: begin r = a ^ b; n = 0; h = 0; c = 0; z = (r == 0); end
      6: begin r = a | b; n = 0; h = 0; c = 0; z = (r == 0); end
      8: begin r = (b + 1) % 256; n = 0; h = (b % 16) == 15; z = (r == 0); end
      9: begin r = (b + 255) % 256; n = 1; h = (b % 16) == 0; z = (r == 0); end
      10: begin
        t = 0;
        if (f[2]) begin
          if (f[1]) t += 6;
          if (f[0]) t += 96;
          r = (a - t + 256) % 256;
        end else begin
          if (f[1] || (a % 16) > 9) t += 6;
          if (f[0] || a > 153) begin t += 96; c = 1; end else c = 0;
          r = (a + t) % 256;
        end
        h = 0; z = (r == 0);
      end
      11: begin r = 255 - a; n = 1; h = 1; end
      12: begin c = 1; n = 0; h = 0; end
      13: begin c = ~f[0]; n = 0; h = 0; end
      default: ;
    endcase
    return {r[7:0], z, n, h, c};
  endfunction

  function automatic string tag_of(input int op);
    case (op)
      0, 1: return "R3";
      2, 3: return "R4";
      7: return "R5";
      4, 5, 6: return "R6";
      8, 9: return "R7";
      10: return "R9/R10";
      11, 12, 13: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic compare(input string req, input logic [11:0] exp);
    checks++;
    if ({res_q, flg_q} !== exp) begin
      errors++;
      $display("FAIL %s: got res=%02h flg=%04b, expected res=%02h flg=%04b",
               req, res_q, flg_q, exp[11:4], exp[3:0]);
    end
  endtask

  // Apply one operation at the falling edge, check after the next rising edge.
  task automatic run_op(input int op, input int a, input int b, input logic [3:0] f, input string req);
    logic [11:0] exp;
    @(negedge clk);
    op_en = 1'b1; op_sel = op[3:0]; acc_in = a[7:0]; opd_in = b[7:0]; flg_in = f;
    exp = model(op, a, b, f);
    @(negedge clk);
    op_en = 1'b0;
    compare(req, exp);
    if (op <= 10 && op != 7) begin
      checks++;
      if (flg_q[3] !== (res_q == 8'h00)) begin
        errors++;
        $display("FAIL R11: got Z=%0b, expected %0b", flg_q[3], (res_q == 8'h00));
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [11:0] held;
    checks = 0; errors = 0; done = 0;
    rst_n = 1'b0; op_en = 1'b0; op_sel = 4'h0;
    acc_in = 8'h00; opd_in = 8'h00; flg_in = 4'h0;
    repeat (3) @(negedge clk);
    // R1: reset state, with an enabled op applied during reset
    op_en = 1'b1; acc_in = 8'h55; opd_in = 8'h11;
    @(negedge clk);
    compare("R1", 12'h000);
    op_en = 1'b0;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    compare("R1", 12'h000);

    // Directed corners
    run_op(0, 8'h0F, 8'h01, 4'h0, "R3");   // half carry only
    run_op(0, 8'hF0, 8'h10, 4'h0, "R3");   // carry, zero
    run_op(1, 8'h0E, 8'h01, 4'h1, "R3");   // carry-in makes H
    run_op(1, 8'hFF, 8'h00, 4'h1, "R3");   // carry-in overflows byte
    run_op(2, 8'h10, 8'h01, 4'h0, "R4");   // nibble borrow
    run_op(3, 8'h00, 8'h00, 4'h1, "R4");   // borrow from carry-in alone
    run_op(7, 8'h42, 8'h42, 4'h0, "R5");   // equal compare
    run_op(7, 8'h10, 8'h20, 4'h8, "R5");   // below
    run_op(4, 8'hF0, 8'h0F, 4'hF, "R6");
    run_op(5, 8'hAA, 8'hAA, 4'h7, "R6");
    run_op(6, 8'h00, 8'h00, 4'h7, "R6");
    run_op(8, 8'h00, 8'hFF, 4'h1, "R7");   // wrap to zero, C kept
    run_op(8, 8'h00, 8'h0F, 4'h0, "R7");
    run_op(9, 8'h00, 8'h00, 4'h1, "R7");   // nibble borrow, C kept
    run_op(9, 8'h00, 8'h01, 4'h0, "R7");
    run_op(11, 8'h00, 8'h00, 4'h8, "R8");  // Z kept although result nonzero
    run_op(12, 8'h00, 8'h00, 4'h8, "R8");
    run_op(13, 8'h12, 8'h00, 4'h1, "R8");
    run_op(10, 8'h9A, 8'h00, 4'h0, "R9");  // both nibble fixes, C set, Z
    run_op(10, 8'h45, 8'h00, 4'h2, "R9");  // H forces low fix
    run_op(10, 8'h12, 8'h00, 4'h1, "R9");  // C forces high fix
    run_op(10, 8'h00, 8'h00, 4'h7, "R10"); // subtract both fixes
    run_op(10, 8'h44, 8'h00, 4'h4, "R10"); // subtract, no fix
    run_op(14, 8'h3C, 8'h99, 4'hA, "R12");
    run_op(15, 8'hC3, 8'h99, 4'h5, "R12");

    // R2: outputs hold while disabled
    held = {res_q, flg_q};
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      op_sel = 4'(i); acc_in = 8'(i * 37 + 1); opd_in = 8'(i * 11); flg_in = 4'(i);
      @(negedge clk);
      compare("R2", held);
    end

    // Constrained random
    void'($urandom(32'd20250515));
    for (int i = 0; i < 3000; i++) begin
      int op; int a; int b; logic [3:0] f;
      op = $urandom % 16;
      a  = $urandom % 256;
      b  = $urandom % 256;
      f  = 4'($urandom % 16);
      if (($urandom % 4) == 0) a = (a % 2 == 0) ? 8'h99 : 8'h9A;
      run_op(op, a, b, f, tag_of(op));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule